// File: doc/BRIEF.md
# Configurable Product-Term Logic Cell

This block is a single logic cell of a programmable logic array. Eighteen input signals feed a configurable AND plane. The plane builds twenty sum product terms and three control product terms. Each term can require any input to be true, complemented, or ignored. Each of the four outputs picks one of four paths: a fast OR of its own group of four terms, a full OR of any subset of the twenty terms followed by an XOR, a single term followed by an XOR, or a forced zero. The second operand of the XOR is one selectable term, or zero. This gives each output a programmable polarity.

Each output is taken either straight from its logic or from a flip-flop. The control terms provide three functions. The first is an asynchronous register clear, which is combined with the active-low global reset. The second is an output-enable level for the I/O cells. The third is a clock term: when it is selected, the registers capture only on its rising transition, sampled on the cell clock. All configuration is loaded one word per cycle through a parallel write port.

Top module: `pterm_logic_cell`

## Requirements
- R1: Configuration addresses 0-19 hold the sum terms, address 20 the clear term, address 21 the output-enable term and address 22 the clock term. In a term word, bits [17:0] require the matching input to be 1, bits [35:18] require it to be 0, and bit 36 enables the term. An enabled term is 1 exactly when every requirement holds, so an enabled term with no requirement is 1. A disabled term is 0.
- R2: Output k is configured at address 23+k. Its bits are [1:0] path, [2] register select, [3] XOR enable, [8:4] XOR term index and [28:9] sum mask. Path 0 gives the OR of terms 4k to 4k+3.
- R3: Path 1 gives the OR of all sum terms whose mask bit is set, XORed with the XOR operand. The operand is the term at the index when XOR is enabled and the index is below 20; otherwise it is 0.
- R4: Path 2 gives term 4k XORed with the XOR operand.
- R5: Path 3 gives a constant 0.
- R6: With register select 0, an output follows its logic in the same cycle. With register select 1, it shows the logic value captured at the last capturing clock edge.
- R7: Address 27 holds bit [0] clear-term enable, bit [1] output-enable-term enable and bit [2] clock select. With clock select 0, every edge captures. With clock select 1, only an edge where the clock term is 1 and was 0 at the previous edge captures.
- R8: `rstN` low clears all registers and all configuration at once, without waiting for a clock edge.
- R9: With its enable set, a true clear term clears the registers at once and holds them at 0. With its enable clear, the clear term has no effect.
- R10: `oe` equals the output-enable term when that term's enable is set, and 1 otherwise.
- R11: A configuration write takes effect from the clock edge that accepts it. After reset, `dout` is 0 and `oe` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Cell clock |
| rstN | input | 1 | Active-low global reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 5 | Configuration word address |
| cfgData | input | 37 | Configuration word |
| din | input | 18 | Logic inputs |
| dout | output | 4 | Cell outputs |
| oe | output | 1 | Output-enable level toward the I/O cells |

## Verification
Combinational results are due in the same cycle. The bench drives `din` on the falling edge and samples two nanoseconds later, before any rising edge can intervene. Registered results appear one rising edge after the stimulus and are sampled two nanoseconds after that edge. The same check also confirms that the value was not visible before the edge. A clear through the term or through `rstN` must show within two nanoseconds, with no edge in between. A configuration write is checked just before its accepting edge, where the old behaviour must still hold, and again one edge later.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

  typedef enum logic [1:0] {
    PATH_FAST   = 2'd0,
    PATH_FULL   = 2'd1,
    PATH_SINGLE = 2'd2,
    PATH_OFF    = 2'd3
  } pathMode_t;

  typedef struct packed {
    logic capture;
    logic clearN;
  } ptcStrobe_t;

endpackage

// File: rtl/ptc_config.sv
module ptc_config #(
  parameter int NUM_IN   = 18,
  parameter int NUM_OUT  = 4,
  parameter int NUM_PT   = 20,
  parameter int SEL_W    = 5,
  parameter int TOTAL_PT = 23,
  parameter int ADDR_W   = 5,
  parameter int CFG_W    = 37
) (
  input  logic clk,
  input  logic rstN,
  input  logic cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [CFG_W-1:0] cfgData,
  output logic [TOTAL_PT-1:0][NUM_IN-1:0] termTrue,
  output logic [TOTAL_PT-1:0][NUM_IN-1:0] termComp,
  output logic [TOTAL_PT-1:0] termEn,
  output logic [NUM_OUT-1:0][1:0] outMode,
  output logic [NUM_OUT-1:0] regSel,
  output logic [NUM_OUT-1:0] xorEn,
  output logic [NUM_OUT-1:0][SEL_W-1:0] xorSel,
  output logic [NUM_OUT-1:0][NUM_PT-1:0] sumMask,
  output logic rstEn,
  output logic oeEn,
  output logic clkSel
);

  localparam int OUT_BASE = TOTAL_PT;
  localparam int CTL_ADDR = TOTAL_PT + NUM_OUT;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      termTrue <= '0;
      termComp <= '0;
      termEn   <= '0;
      outMode  <= '0;
      regSel   <= '0;
      xorEn    <= '0;
      xorSel   <= '0;
      sumMask  <= '0;
      rstEn    <= 1'b0;
      oeEn     <= 1'b0;
      clkSel   <= 1'b0;
    end else if (cfgWe) begin
      for (int t = 0; t < TOTAL_PT; t++) begin
        if (cfgAddr == ADDR_W'(t)) begin
          termTrue[t] <= cfgData[NUM_IN-1:0];
          termComp[t] <= cfgData[2*NUM_IN-1:NUM_IN];
          termEn[t]   <= cfgData[2*NUM_IN];
        end
      end
      for (int k = 0; k < NUM_OUT; k++) begin
        if (cfgAddr == ADDR_W'(OUT_BASE + k)) begin
          outMode[k] <= cfgData[1:0];
          regSel[k]  <= cfgData[2];
          xorEn[k]   <= cfgData[3];
          xorSel[k]  <= cfgData[4 +: SEL_W];
          sumMask[k] <= cfgData[4+SEL_W +: NUM_PT];
        end
      end
      if (cfgAddr == ADDR_W'(CTL_ADDR)) begin
        rstEn  <= cfgData[0];
        oeEn   <= cfgData[1];
        clkSel <= cfgData[2];
      end
    end
  end

endmodule

// File: rtl/ptc_control.sv
module ptc_control
  import ptc_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic rstEn,
  input  logic oeEn,
  input  logic clkSel,
  input  logic rstTerm,
  input  logic oeTerm,
  input  logic clkTerm,
  output ptcStrobe_t strobe,
  output logic oe
);

  logic prevClk;

  // Clock term sampled on the cell clock; its rising transition becomes a capture strobe.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevClk <= 1'b0;
    else       prevClk <= clkTerm;
  end

  always_comb begin
    strobe.capture = clkSel ? (clkTerm & ~prevClk) : 1'b1;
    strobe.clearN  = rstN & ~(rstEn & rstTerm);
  end

  assign oe = oeEn ? oeTerm : 1'b1;

endmodule

// File: rtl/ptc_datapath.sv
module ptc_datapath
  import ptc_pkg::*;
#(
  parameter int NUM_IN   = 18,
  parameter int NUM_OUT  = 4,
  parameter int NUM_PT   = 20,
  parameter int FAST_PT  = 4,
  parameter int SEL_W    = 5,
  parameter int TOTAL_PT = 23
) (
  input  logic clk,
  input  logic [NUM_IN-1:0] din,
  input  logic [TOTAL_PT-1:0][NUM_IN-1:0] termTrue,
  input  logic [TOTAL_PT-1:0][NUM_IN-1:0] termComp,
  input  logic [TOTAL_PT-1:0] termEn,
  input  logic [NUM_OUT-1:0][1:0] outMode,
  input  logic [NUM_OUT-1:0] regSel,
  input  logic [NUM_OUT-1:0] xorEn,
  input  logic [NUM_OUT-1:0][SEL_W-1:0] xorSel,
  input  logic [NUM_OUT-1:0][NUM_PT-1:0] sumMask,
  input  ptcStrobe_t strobe,
  output logic rstTerm,
  output logic oeTerm,
  output logic clkTerm,
  output logic [NUM_OUT-1:0] logicVal,
  output logic [NUM_OUT-1:0] regQ,
  output logic [NUM_OUT-1:0] dout
);

  logic [TOTAL_PT-1:0] pt;
  logic clearN;

  // AND plane: each term checks its true and complement requirements.
  for (genvar t = 0; t < TOTAL_PT; t++) begin : gTerm
    logic [NUM_IN-1:0] okBits;
    assign okBits = (~termTrue[t] | din) & (~termComp[t] | ~din);
    assign pt[t]  = termEn[t] & (&okBits);
  end

  assign rstTerm = pt[NUM_PT];
  assign oeTerm  = pt[NUM_PT+1];
  assign clkTerm = pt[NUM_PT+2];

  // OR / XOR stage, one per output.
  for (genvar k = 0; k < NUM_OUT; k++) begin : gOut
    logic fastHit;
    logic sumHit;
    logic inRange;
    logic xorOp;
    logic res;

    assign fastHit = |pt[k*FAST_PT +: FAST_PT];
    assign sumHit  = |(pt[NUM_PT-1:0] & sumMask[k]);
    assign inRange = {1'b0, xorSel[k]} < (SEL_W+1)'(NUM_PT);
    assign xorOp   = xorEn[k] & inRange & pt[xorSel[k]];

    always_comb begin
      unique case (pathMode_t'(outMode[k]))
        PATH_FAST:   res = fastHit;
        PATH_FULL:   res = sumHit ^ xorOp;
        PATH_SINGLE: res = pt[k*FAST_PT] ^ xorOp;
        default:     res = 1'b0;
      endcase
    end

    assign logicVal[k] = res;
  end

  assign clearN = strobe.clearN;

  always_ff @(posedge clk or negedge clearN) begin
    if (!clearN)             regQ <= '0;
    else if (strobe.capture) regQ <= logicVal;
  end

  assign dout = (regSel & regQ) | (~regSel & logicVal);

endmodule

// File: rtl/pterm_logic_cell.sv
module pterm_logic_cell
  import ptc_pkg::*;
#(
  parameter int NUM_IN  = 18,
  parameter int NUM_OUT = 4,
  parameter int NUM_PT  = 20,
  parameter int FAST_PT = 4,
  localparam int SEL_W    = $clog2(NUM_PT),
  localparam int TOTAL_PT = NUM_PT + 3,
  localparam int NUM_WORD = TOTAL_PT + NUM_OUT + 1,
  localparam int ADDR_W   = $clog2(NUM_WORD),
  localparam int TERM_W   = 2*NUM_IN + 1,
  localparam int OUTW_W   = 4 + SEL_W + NUM_PT,
  localparam int CFG_W    = (TERM_W > OUTW_W) ? TERM_W : OUTW_W
) (
  input  logic clk,
  input  logic rstN,
  input  logic cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [CFG_W-1:0] cfgData,
  input  logic [NUM_IN-1:0] din,
  output logic [NUM_OUT-1:0] dout,
  output logic oe
);

  logic [TOTAL_PT-1:0][NUM_IN-1:0] cfgTermTrue;
  logic [TOTAL_PT-1:0][NUM_IN-1:0] cfgTermComp;
  logic [TOTAL_PT-1:0] cfgTermEn;
  logic [NUM_OUT-1:0][1:0] cfgOutMode;
  logic [NUM_OUT-1:0] cfgRegSel;
  logic [NUM_OUT-1:0] cfgXorEn;
  logic [NUM_OUT-1:0][SEL_W-1:0] cfgXorSel;
  logic [NUM_OUT-1:0][NUM_PT-1:0] cfgSumMask;
  logic cfgRstEn;
  logic cfgOeEn;
  logic cfgClkSel;
  logic ctlRstTerm;
  logic ctlOeTerm;
  logic ctlClkTerm;
  logic [NUM_OUT-1:0] logicVal;
  logic [NUM_OUT-1:0] regQ;
  ptcStrobe_t strobe;

  ptc_config #(
    .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .NUM_PT(NUM_PT), .SEL_W(SEL_W),
    .TOTAL_PT(TOTAL_PT), .ADDR_W(ADDR_W), .CFG_W(CFG_W)
  ) uConfig (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .termTrue(cfgTermTrue), .termComp(cfgTermComp), .termEn(cfgTermEn),
    .outMode(cfgOutMode), .regSel(cfgRegSel), .xorEn(cfgXorEn), .xorSel(cfgXorSel),
    .sumMask(cfgSumMask), .rstEn(cfgRstEn), .oeEn(cfgOeEn), .clkSel(cfgClkSel)
  );

  ptc_control uControl (
    .clk(clk), .rstN(rstN), .rstEn(cfgRstEn), .oeEn(cfgOeEn), .clkSel(cfgClkSel),
    .rstTerm(ctlRstTerm), .oeTerm(ctlOeTerm), .clkTerm(ctlClkTerm),
    .strobe(strobe), .oe(oe)
  );

  ptc_datapath #(
    .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .NUM_PT(NUM_PT), .FAST_PT(FAST_PT),
    .SEL_W(SEL_W), .TOTAL_PT(TOTAL_PT)
  ) uDatapath (
    .clk(clk), .din(din),
    .termTrue(cfgTermTrue), .termComp(cfgTermComp), .termEn(cfgTermEn),
    .outMode(cfgOutMode), .regSel(cfgRegSel), .xorEn(cfgXorEn), .xorSel(cfgXorSel),
    .sumMask(cfgSumMask), .strobe(strobe),
    .rstTerm(ctlRstTerm), .oeTerm(ctlOeTerm), .clkTerm(ctlClkTerm),
    .logicVal(logicVal), .regQ(regQ), .dout(dout)
  );

endmodule

// File: rtl/ptc_cell_checker.sv
module ptc_cell_checker
  import ptc_pkg::*;
#(
  parameter int NUM_OUT = 4
) (
  input logic clk,
  input logic rstN,
  input ptcStrobe_t strobe,
  input logic rstEn,
  input logic rstTerm,
  input logic clkSel,
  input logic clkTerm,
  input logic oeEn,
  input logic oe,
  input logic [NUM_OUT-1:0] regSel,
  input logic [NUM_OUT-1:0] logicVal,
  input logic [NUM_OUT-1:0] regQ,
  input logic [NUM_OUT-1:0] dout
);

  assert_global_clear_R8: assert property (@(posedge clk)
    !rstN |-> regQ == '0);

  assert_term_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rstEn && rstTerm) |-> regQ == '0);

  assert_capture_R6: assert property (@(posedge clk) disable iff (!strobe.clearN)
    (strobe.capture && strobe.clearN) |=> (!strobe.clearN || regQ == $past(logicVal)));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!strobe.clearN)
    (!strobe.capture && strobe.clearN) |=> (!strobe.clearN || $stable(regQ)));

  assert_edge_capture_R7: assert property (@(posedge clk) disable iff (!rstN)
    (clkSel && strobe.capture) |-> (clkTerm && !$past(clkTerm)));

  assert_comb_path_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((dout ^ logicVal) & ~regSel) == '0);

  assert_oe_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !oeEn |-> oe);

endmodule

bind pterm_logic_cell ptc_cell_checker #(.NUM_OUT(NUM_OUT)) uChk (
  .clk(clk), .rstN(rstN), .strobe(strobe), .rstEn(cfgRstEn), .rstTerm(ctlRstTerm),
  .clkSel(cfgClkSel), .clkTerm(ctlClkTerm), .oeEn(cfgOeEn), .oe(oe),
  .regSel(cfgRegSel), .logicVal(logicVal), .regQ(regQ), .dout(dout)
);

// File: tb/pterm_logic_cell_test.sv
module pterm_logic_cell_test;

  logic clk = 1'b0;
  logic rstN = 1'b1;
  logic cfgWe = 1'b0;
  logic [4:0] cfgAddr = '0;
  logic [36:0] cfgData = '0;
  logic [17:0] din = '0;
  logic [3:0] dout;
  logic oe;

  int nTests = 0;
  int nFail = 0;

  // Bench copy of the configuration
  logic [17:0] mT [23];
  logic [17:0] mC [23];
  logic mE [23];
  logic [1:0] oMode [4];
  logic oReg [4];
  logic oXe [4];
  logic [4:0] oXs [4];
  logic [19:0] oMask [4];
  logic cRst, cOe, cClk;

  pterm_logic_cell uut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .din(din), .dout(dout), .oe(oe)
  );

  always #10 clk = ~clk;

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic termVal(int t, logic [17:0] d);
    return mE[t] && ((d & mT[t]) == mT[t]) && ((~d & mC[t]) == mC[t]);
  endfunction

  function automatic logic [3:0] modelOut(logic [17:0] d);
    logic [19:0] p;
    logic [3:0] r;
    for (int t = 0; t < 20; t++) p[t] = termVal(t, d);
    for (int k = 0; k < 4; k++) begin
      logic x;
      x = (oXe[k] && oXs[k] < 20) ? p[oXs[k]] : 1'b0;
      case (oMode[k])
        2'd0: r[k] = (p[4*k] | p[4*k+1] | p[4*k+2] | p[4*k+3]);
        2'd1: r[k] = ((p & oMask[k]) != 0) ^ x;
        2'd2: r[k] = p[4*k] ^ x;
        default: r[k] = 1'b0;
      endcase
    end
    return r;
  endfunction

  function automatic string tagOf(logic [1:0] m);
    case (m)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic cfgWrite(int a, logic [36:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = 5'(a); cfgData = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic pushAll();
    for (int t = 0; t < 23; t++) cfgWrite(t, {mE[t], mC[t], mT[t]});
    for (int k = 0; k < 4; k++)
      cfgWrite(23 + k, {8'b0, oMask[k], oXs[k], oXe[k], oReg[k], oMode[k]});
    cfgWrite(27, {34'b0, cClk, cOe, cRst});
  endtask

  task automatic clearCfg();
    for (int t = 0; t < 23; t++) begin mT[t] = '0; mC[t] = '0; mE[t] = 1'b0; end
    for (int k = 0; k < 4; k++) begin
      oMode[k] = 2'd3; oReg[k] = 1'b0; oXe[k] = 1'b0; oXs[k] = '0; oMask[k] = '0;
    end
    cRst = 1'b0; cOe = 1'b0; cClk = 1'b0;
  endtask

  // Random configuration whose sum terms depend only on din[5:0]
  task automatic genCfg(int variant, logic [3:0] regs);
    clearCfg();
    for (int t = 0; t < 20; t++) begin
      mT[t] = 18'($urandom) & 18'($urandom) & 18'h3F;
      mC[t] = 18'($urandom) & 18'($urandom) & 18'h3F & ~mT[t];
      mE[t] = ($urandom % 5) != 0;
    end
    for (int k = 0; k < 4; k++) begin
      oMode[k] = 2'((k + variant) % 4);
      oReg[k]  = regs[k];
      oXe[k]   = 1'($urandom);
      oXs[k]   = 5'($urandom % 24);
      oMask[k] = 20'($urandom) & 20'($urandom);
    end
  endtask

  task automatic drive(logic [17:0] v);
    @(negedge clk);
    din = v;
    #2;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin : main
    logic [3:0] exp, prevExp, regMask;
    logic prevB;
    clearCfg();
    #1 rstN = 1'b0;
    #2;
    check("R8 clear during reset", dout, 4'h0);
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #2;
    check("R11 dout after reset", dout, 4'h0);
    check("R11 oe after reset", {3'b0, oe}, 4'h1);

    // R1 directed term evaluation
    clearCfg();
    mT[0] = 18'h5; mC[0] = 18'h2; mE[0] = 1'b1;
    mE[1] = 1'b1;
    oMode[0] = 2'd1; oMask[0] = 20'h1;
    oMode[1] = 2'd1; oMask[1] = 20'h2;
    oMode[2] = 2'd1; oMask[2] = 20'h4;
    oMode[3] = 2'd0;
    pushAll();
    drive(18'h00005); check("R1 term match", dout, 4'b0011);
    drive(18'h00007); check("R1 complement miss", dout, 4'b0010);
    drive(18'h00004); check("R1 true miss", dout, 4'b0010);
    drive(18'h3FFFD); check("R1 extra inputs ignored", dout, 4'b0011);

    // R11 write timing: output 1 to path 3
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = 5'd24; cfgData = 37'd3;
    #2 check("R11 old config before edge", {3'b0, dout[1]}, 4'h1);
    @(negedge clk); cfgWe = 1'b0;
    #2 check("R11 new config after edge", {3'b0, dout[1]}, 4'h0);

    // Exhaustive sweep of din[5:0] under several random configurations
    for (int variant = 0; variant < 6; variant++) begin
      genCfg(variant, 4'b0000);
      pushAll();
      for (int v = 0; v < 64; v++) begin
        drive({12'($urandom), 6'(v)});
        exp = modelOut(din);
        for (int k = 0; k < 4; k++)
          check(tagOf(oMode[k]), {3'b0, dout[k]}, {3'b0, exp[k]});
      end
      check("R10 oe idle", {3'b0, oe}, 4'h1);
    end

    // R6 registered versus combinational outputs, clock select 0
    regMask = 4'b1011;
    genCfg(1, regMask);
    pushAll();
    drive({12'($urandom), 6'($urandom)});
    @(posedge clk); #2;
    prevExp = modelOut(din);
    check("R6 registered capture", dout, prevExp);
    for (int i = 0; i < 24; i++) begin
      drive({12'($urandom), 6'($urandom)});
      exp = modelOut(din);
      check("R6 before edge", dout, (regMask & prevExp) | (~regMask & exp));
      @(posedge clk); #2;
      check("R6 after edge", dout, exp);
      prevExp = exp;
    end

    // R7 clock term on din[17]
    genCfg(2, 4'b1111);
    mT[22] = 18'h20000; mE[22] = 1'b1; cClk = 1'b1;
    pushAll();
    drive({1'b1, 11'($urandom), 6'($urandom)});
    @(posedge clk); #2;
    prevExp = modelOut(din);
    check("R7 first rise captures", dout, prevExp);
    prevB = 1'b1;
    for (int i = 0; i < 16; i++) begin
      logic b;
      b = (i % 3) != 1;
      drive({b, 11'($urandom), 6'($urandom)});
      exp = modelOut(din);
      @(posedge clk); #2;
      if (b && !prevB) prevExp = exp;
      check("R7 clock term edge", dout, prevExp);
      prevB = b;
    end

    // R9 clear term on din[16], R10 enable term on din[15]
    clearCfg();
    mE[1] = 1'b1;
    oMode[0] = 2'd1; oMask[0] = 20'h2; oReg[0] = 1'b1;
    mT[20] = 18'h10000; mE[20] = 1'b1; cRst = 1'b1;
    mT[21] = 18'h08000; mE[21] = 1'b1;
    pushAll();
    drive(18'h00000);
    @(posedge clk); #2;
    check("R9 precondition", dout, 4'b0001);
    drive(18'h10000);
    check("R9 clear without edge", dout, 4'b0000);
    @(posedge clk); #2;
    check("R9 clear held over edge", dout, 4'b0000);
    drive(18'h00000);
    check("R9 released, no edge yet", dout, 4'b0000);
    @(posedge clk); #2;
    check("R9 capture after release", dout, 4'b0001);
    cRst = 1'b0;
    cfgWrite(27, {34'b0, cClk, cOe, cRst});
    drive(18'h10000);
    check("R9 disabled term no effect", dout, 4'b0001);
    @(posedge clk); #2;
    check("R9 disabled term over edge", dout, 4'b0001);

    drive(18'h00000);
    check("R10 disabled term gives 1", {3'b0, oe}, 4'h1);
    cOe = 1'b1;
    cfgWrite(27, {34'b0, cClk, cOe, cRst});
    #2 check("R10 term low", {3'b0, oe}, 4'h0);
    drive(18'h08000);
    check("R10 term high", {3'b0, oe}, 4'h1);

    // R8 global reset mid-run
    check("R8 precondition", dout, 4'b0001);
    @(negedge clk); rstN = 1'b0;
    #2;
    check("R8 async clear", dout, 4'b0000);
    check("R8 oe after clear", {3'b0, oe}, 4'h1);
    repeat (2) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    drive(18'h3FFFF);
    check("R8 config cleared", dout, 4'b0000);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule